// File: doc/BRIEF.md
# Reference Clock Power Mode Controller

This block decides when the bit-clock generator and the serial I/O of a serial link endpoint are powered. It takes a two-bit mode-select input and a raw reference clock. When both mode-select bits are low the block holds everything off. When the mode is non-zero and the reference clock toggles, the block enables the clock generator and the serial I/O. It then counts reference cycles before it raises a lock-valid flag, which gates capture into the parallel port.

Reference activity is measured in a free-running fast clock domain. The raw reference passes through a synchroniser, and any transition resets an idle counter. If the reference stays at one level for too many fast-clock samples, the block shuts the generator and the serial I/O down. The next transition restarts them.

The analog loop itself is modelled only by its enable and by a lock counter. A start from the mode-select power-down state uses the long cold count. A restart after a stall uses the shorter warm count, because internal references stay powered through a stall.

Top module: `refclk_power_ctrl`

## Requirements
- R1: While `mode_sel` is 2'b00, `pll_en`, `sio_en` and `lock_valid` are all low in that same cycle, without waiting for any reference edge.
- R2: In the powered-down state with a non-zero `mode_sel`, a synchronised reference transition makes `pll_en` and `sio_en` go high on the next clock. `sio_en` always equals `pll_en`.
- R3: After a start from mode-select power-down, `lock_valid` rises on the clock that follows the COLD_LOCK-th synchronised rising reference edge counted while locking.
- R4: When STALL_SAMPLES consecutive fast-clock samples pass with no synchronised reference transition, a stall is declared. In the cycle the stall is declared, `pll_en`, `sio_en` and `lock_valid` all drop.
- R5: After a stall, the first synchronised reference transition re-enables the generator. The lock then uses WARM_LOCK rising edges, and WARM_LOCK is smaller than COLD_LOCK.
- R6: `lock_valid` is never high while `pll_en` is low.
- R7: The raw reference goes through two flip-flops before edge detection. A transition driven on `ref_clk_in` can re-enable the generator no sooner than the third rising edge of `clk_fast` after it.
- R8: Changing `mode_sel` from one non-zero code to another has no effect on the outputs.
- R9: During and after reset, all three outputs are low until a reference transition is seen with a non-zero mode.
- R10: Entering mode 2'b00 from any state and leaving it again always uses the cold lock count, even if the previous lock was a warm one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode select; 2'b00 is power-down, any other code is active |
| ref_clk_in | input | 1 | Raw reference clock, asynchronous to `clk_fast` |
| pll_en | output | 1 | Enable for the bit-clock generator |
| sio_en | output | 1 | Enable for the serial I/O |
| lock_valid | output | 1 | High once the lock wait has elapsed; gates parallel capture |

## Verification
The checker watches several properties on every cycle. A low mode forces all outputs off, and a declared stall forces them off in that same cycle. `lock_valid` implies `pll_en`, and `sio_en` tracks `pll_en`. Every rise of `pll_en` follows a detected reference transition, and every rise of `lock_valid` follows a counted rising edge. The exact lengths of the cold and warm lock waits cannot be seen from a single cycle, nor can the choice between them after a stall or after a mode power-down, nor the synchroniser latency. The bench's scenarios cover these, comparing against a cycle-by-cycle model and measuring the wait intervals.

// File: rtl/rcpm_pkg.sv
package rcpm_pkg;

  typedef enum logic [1:0] {
    PM_OFF      = 2'd0,
    PM_LOCKING  = 2'd1,
    PM_LOCKED   = 2'd2,
    PM_STALLED  = 2'd3
  } pm_state_t;

  // Terminal value of the lock counter for the selected restart kind.
  function automatic int unsigned lock_last(input logic warm,
                                            input int unsigned cold_len,
                                            input int unsigned warm_len);
    return warm ? (warm_len - 1) : (cold_len - 1);
  endfunction

  // True when the mode-select code means power-down.
  function automatic logic is_power_down(input logic [1:0] code);
    return (code == 2'b00);
  endfunction

endpackage

// File: rtl/rcpm_ref_sync.sv
module rcpm_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic any_edge,
  output logic rise_edge
);
  logic [STAGES-1:0] sync_q;
  logic              hist_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= raw_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= sync_q[STAGES-1];
  end

  assign any_edge  = sync_q[STAGES-1] ^ hist_q;
  assign rise_edge = sync_q[STAGES-1] & ~hist_q;
endmodule

// File: rtl/rcpm_stall_watch.sv
module rcpm_stall_watch #(
  parameter int unsigned STALL_SAMPLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seen_edge,
  output logic stalled
);
  localparam int unsigned IW = $clog2(STALL_SAMPLES + 1);
  localparam logic [IW-1:0] IDLE_MAX = IW'(STALL_SAMPLES);

  logic [IW-1:0] idle_q;

  // Starts saturated: no reference has been observed after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               idle_q <= IDLE_MAX;
    else if (seen_edge)       idle_q <= '0;
    else if (idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
  end

  assign stalled = (idle_q == IDLE_MAX);
endmodule

// File: rtl/rcpm_lock_timer.sv
module rcpm_lock_timer
  import rcpm_pkg::*;
#(
  parameter int unsigned COLD_LOCK = 32,
  parameter int unsigned WARM_LOCK = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic restart_warm,
  input  logic count_pulse,
  output logic reached
);
  localparam int unsigned LW = $clog2(COLD_LOCK + 1);

  logic [LW-1:0] cnt_q;
  logic          warm_q;
  logic [LW-1:0] last_val;

  assign last_val = LW'(lock_last(warm_q, COLD_LOCK, WARM_LOCK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      warm_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      warm_q <= restart_warm;
    end else if (count_pulse && (cnt_q != last_val)) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign reached = count_pulse && (cnt_q == last_val);
endmodule

// File: rtl/refclk_power_ctrl.sv
module refclk_power_ctrl
  import rcpm_pkg::*;
#(
  parameter int unsigned STALL_SAMPLES = 64,
  parameter int unsigned COLD_LOCK     = 32,
  parameter int unsigned WARM_LOCK     = 8,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk_fast,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       ref_clk_in,
  output logic       pll_en,
  output logic       sio_en,
  output logic       lock_valid
);
  // Named internal events, observed by the bound checker.
  logic      ref_edge;
  logic      ref_rise;
  logic      stall_det;
  logic      lock_reached;
  logic      mode_off;
  logic      tmr_restart;
  logic      tmr_warm;
  pm_state_t pm_state, pm_next;

  rcpm_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_fast), .rst_n(rst_n), .raw_in(ref_clk_in),
    .any_edge(ref_edge), .rise_edge(ref_rise)
  );

  rcpm_stall_watch #(.STALL_SAMPLES(STALL_SAMPLES)) u_watch (
    .clk(clk_fast), .rst_n(rst_n), .seen_edge(ref_edge), .stalled(stall_det)
  );

  rcpm_lock_timer #(.COLD_LOCK(COLD_LOCK), .WARM_LOCK(WARM_LOCK)) u_timer (
    .clk(clk_fast), .rst_n(rst_n), .restart(tmr_restart),
    .restart_warm(tmr_warm),
    .count_pulse(ref_rise && (pm_state == PM_LOCKING) && !stall_det),
    .reached(lock_reached)
  );

  assign mode_off = is_power_down(mode_sel);

  always_comb begin
    pm_next     = pm_state;
    tmr_restart = 1'b0;
    tmr_warm    = 1'b0;
    if (mode_off) begin
      pm_next = PM_OFF;
    end else begin
      unique case (pm_state)
        PM_OFF: if (ref_edge) begin
          pm_next     = PM_LOCKING;
          tmr_restart = 1'b1;
        end
        PM_LOCKING: begin
          if (stall_det)         pm_next = PM_STALLED;
          else if (lock_reached) pm_next = PM_LOCKED;
        end
        PM_LOCKED: if (stall_det) pm_next = PM_STALLED;
        PM_STALLED: if (ref_edge) begin
          pm_next     = PM_LOCKING;
          tmr_restart = 1'b1;
          tmr_warm    = 1'b1;
        end
        default: pm_next = PM_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) pm_state <= PM_OFF;
    else        pm_state <= pm_next;
  end

  // Shutdowns act in the same cycle as their cause.
  logic running;
  assign running    = !mode_off && !stall_det &&
                      ((pm_state == PM_LOCKING) || (pm_state == PM_LOCKED));
  assign pll_en     = running;
  assign sio_en     = running;
  assign lock_valid = running && (pm_state == PM_LOCKED);

  initial begin
    if (!(COLD_LOCK > WARM_LOCK && WARM_LOCK > 0))
      $display("refclk_power_ctrl: COLD_LOCK must exceed WARM_LOCK > 0");
  end
endmodule

// File: rtl/rcpm_checker.sv
module rcpm_checker (
  input logic       clk_fast,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       pll_en,
  input logic       sio_en,
  input logic       lock_valid,
  input logic       ref_edge,
  input logic       ref_rise,
  input logic       stall_det
);
  assert_mode_off_R1: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (mode_sel == 2'b00) |-> (!pll_en && !sio_en && !lock_valid));

  assert_sio_tracks_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
    sio_en == pll_en);

  assert_wake_on_edge_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $rose(pll_en) |-> $past(ref_edge));

  assert_lock_on_rise_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $rose(lock_valid) |-> $past(ref_rise));

  assert_stall_shutdown_R4: assert property (@(posedge clk_fast) disable iff (!rst_n)
    stall_det |-> (!pll_en && !sio_en && !lock_valid));

  assert_valid_needs_pll_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
    lock_valid |-> pll_en);
endmodule

bind refclk_power_ctrl rcpm_checker u_chk (
  .clk_fast(clk_fast), .rst_n(rst_n), .mode_sel(mode_sel),
  .pll_en(pll_en), .sio_en(sio_en), .lock_valid(lock_valid),
  .ref_edge(ref_edge), .ref_rise(ref_rise), .stall_det(stall_det)
);

// File: tb/refclk_power_ctrl_bench.sv
`timescale 1ns/1ps
module refclk_power_ctrl_bench;
  localparam int STALL = 64;
  localparam int COLD  = 32;
  localparam int WARM  = 8;
  localparam int HALF  = 4;   // reference half period in fast cycles
  localparam int LIMIT = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       ref_lvl = 1'b0;
  logic       pll_en, sio_en, lock_valid;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  bit done    = 0;
  bit ref_run = 1;
  int ph      = 0;
  string cur_req = "R9";

  always #4 clk = ~clk;  // 125 MHz

  refclk_power_ctrl #(.STALL_SAMPLES(STALL), .COLD_LOCK(COLD), .WARM_LOCK(WARM))
    u_refclk_power_ctrl (
      .clk_fast(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_clk_in(ref_lvl),
      .pll_en(pll_en), .sio_en(sio_en), .lock_valid(lock_valid));

  // Behavioural reference model: 0 off, 1 locking, 2 locked, 3 stalled.
  bit hist[$] = '{0, 0, 0};
  int m_st = 0, m_idle = STALL, m_cnt = 0, m_goal = COLD;

  always @(posedge clk) begin
    bit e, r, st;
    if (!rst_n) begin
      hist = '{0, 0, 0}; m_st = 0; m_idle = STALL; m_cnt = 0; m_goal = COLD;
    end else begin
      e  = hist[1] != hist[2];
      r  = hist[1] && !hist[2];
      st = m_idle >= STALL;
      if (mode_sel == 2'b00) m_st = 0;
      else if (m_st == 0 && e) begin m_st = 1; m_cnt = 0; m_goal = COLD; end
      else if (m_st == 3 && e) begin m_st = 1; m_cnt = 0; m_goal = WARM; end
      else if ((m_st == 1 || m_st == 2) && st) m_st = 3;
      else if (m_st == 1 && r) begin
        m_cnt++;
        if (m_cnt >= m_goal) m_st = 2;
      end
      m_idle = e ? 0 : ((m_idle < STALL) ? m_idle + 1 : STALL);
      hist.push_front(ref_lvl);
      void'(hist.pop_back());
    end
  end

  function automatic bit m_run();
    return (mode_sel != 2'b00) && (m_idle < STALL) && (m_st == 1 || m_st == 2);
  endfunction

  task automatic check(input string req, input bit got, input bit exp, input string what);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b expected %b (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  int t_pll = 0, t_lv = 0, last_lock = 0;
  bit prev_pll = 0, prev_lv = 0;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      check(cur_req, pll_en,     m_run(),             "pll_en");
      check(cur_req, sio_en,     m_run(),             "sio_en");
      check(cur_req, lock_valid, m_run() && m_st == 2, "lock_valid");
      if (pll_en && !prev_pll) t_pll = cyc;
      if (lock_valid && !prev_lv) begin t_lv = cyc; last_lock = t_lv - t_pll; end
      prev_pll = pll_en; prev_lv = lock_valid;
      if (ref_run) begin
        ph++;
        if (ph == HALF) begin ph = 0; ref_lvl = ~ref_lvl; end
      end
    end
  endtask

  task automatic check_window(input string req, input int got, input int n);
    vectors++;
    if (got < (n - 1) * 2 * HALF || got > (n + 1) * 2 * HALF) begin
      errors++;
      $display("FAIL %s lock wait got %0d expected %0d..%0d", req, got,
               (n - 1) * 2 * HALF, (n + 1) * 2 * HALF);
    end
  endtask

  initial begin
    int cold_a, warm_a;
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", pll_en, 0, "pll_en in reset");
    check("R9", lock_valid, 0, "lock_valid in reset");
    rst_n = 1'b1;
    // R1: running reference but power-down code
    cur_req = "R1"; step(20);
    check("R1", pll_en, 0, "pll_en mode 00");
    // R2/R3: cold start
    cur_req = "R3"; mode_sel = 2'b01; step(400);
    check("R3", lock_valid, 1, "lock_valid after cold wait");
    cold_a = last_lock;
    check_window("R3", cold_a, COLD);
    // R8: switch between active codes
    cur_req = "R8"; mode_sel = 2'b10; step(30);
    check("R8", lock_valid, 1, "lock_valid kept on code change");
    // R4: reference held high
    cur_req = "R4"; ref_run = 0; step(100);
    check("R4", pll_en, 0, "pll_en after stall");
    check("R4", sio_en, 0, "sio_en after stall");
    // R5: warm restart
    cur_req = "R5"; ref_run = 1; step(150);
    check("R5", lock_valid, 1, "lock_valid after warm wait");
    warm_a = last_lock;
    check_window("R5", warm_a, WARM);
    vectors++;
    if (!(warm_a < cold_a)) begin
      errors++;
      $display("FAIL R5 warm wait got %0d expected below %0d", warm_a, cold_a);
    end
    // R1 then R10: power-down resets to cold count
    cur_req = "R1"; mode_sel = 2'b00; step(20);
    check("R1", lock_valid, 0, "lock_valid mode 00 after warm lock");
    cur_req = "R10"; mode_sel = 2'b11; step(400);
    check_window("R10", last_lock, COLD);
    // R4 during locking, reference held low
    cur_req = "R4"; mode_sel = 2'b00; step(10);
    mode_sel = 2'b01; step(60);
    ref_run = 0; if (ref_lvl) begin ref_lvl = 0; end step(100);
    check("R4", pll_en, 0, "pll_en stall while locking");
    // R7: synchroniser latency of a single transition
    cur_req = "R7"; ref_lvl = 1'b1;
    step(1); check("R7", pll_en, 0, "pll_en one edge after transition");
    step(1); check("R7", pll_en, 0, "pll_en two edges after transition");
    step(1); check("R7", pll_en, 1, "pll_en three edges after transition");
    cur_req = "R5"; ph = 0; ref_run = 1; step(150);
    check("R5", lock_valid, 1, "lock_valid warm after manual wake");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule